// File: doc/BRIEF.md
# JTAG Test Access Port with Debug Access Register

This block is a JTAG test access port clocked by `tck`. A 16-state TAP controller steps on `tms`. A 4-bit instruction register picks one of three data registers to sit between `tdi` and `tdo`: a one-bit bypass stage, a 32-bit identification word, and a 35-bit debug access register. The access register links the serial scan chain to a debug register file through a simple request/response pair. The register file itself lies outside this block.

A debugger loads the access instruction and shifts in a request made of write data, a two-bit register address and a read/write flag. At Update-DR the block sends out a one-cycle request strobe that carries these fields. The register file answers with a response strobe, read data and a 3-bit acknowledge, which the block holds. The next Capture-DR moves that response into the access register, so the debugger shifts it out while it shifts in the next request. If no answer has come back, the capture carries a WAIT acknowledge instead.

Top module: `jtag_dap_tap`

## Requirements
- R1: When `trst` is high at a rising `tck` edge, the controller goes to Test-Logic-Reset and the instruction becomes the identification code 4'b1110. Five rising edges with `tms` high also reach Test-Logic-Reset from any state, and that state reloads 4'b1110.
- R2: The controller follows the IEEE 1149.1 16-state transition graph. It stays in Test-Logic-Reset while `tms` is high.
- R3: Capture-IR loads 4'b0001 into the instruction shift stage. Instruction bits shift least significant bit first. The active instruction changes only at Update-IR or on reset.
- R4: Instruction 4'b1111 selects the one-bit bypass register, which captures 0 and delays `tdi` by one shift. Every code other than 4'b1110 and 4'b1010 also selects bypass.
- R5: Instruction 4'b1110 selects the 32-bit identification register, which captures 32'h3BA00477.
- R6: Instruction 4'b1010 selects the 35-bit access register. In the shifted-in word, bits 34:3 are write data, bits 2:1 are the register address, and bit 0 is the direction flag (1 = read, 0 = write).
- R7: Update-DR under instruction 4'b1010 raises `req_valid` for exactly one cycle, starting at the rising edge that leaves Update-DR. `req_wdata`, `req_addr` and `req_rnw` hold the shifted-in fields. Update-DR under any other instruction raises no request.
- R8: A response presented with `rsp_valid` at a rising edge before Capture-DR is stored. That Capture-DR loads the stored read data into bits 34:3 and the stored acknowledge into bits 2:0. Acknowledge codes pass unchanged: 3'b010 is OK/FAULT, 3'b001 is WAIT, and the rest are reserved.
- R9: If no response has been stored since the last request or since `trst`, Capture-DR loads the acknowledge 3'b001. The data field then repeats the last stored read data, which is zero after `trst`.
- R10: `tdo` changes on the falling `tck` edge. In Shift-DR and Shift-IR it shows the least significant bit of the selected register. In every other state it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| req_valid | output | 1 | One-cycle request strobe |
| req_addr | output | ADDR_W | Debug register address of the request |
| req_rnw | output | 1 | 1 = read request, 0 = write request |
| req_wdata | output | DATA_W | Write data of the request |
| rsp_valid | input | 1 | Response strobe from the register file |
| rsp_ack | input | ADDR_W+1 | Acknowledge code of the response |
| rsp_rdata | input | DATA_W | Read data of the response |

## Verification
The bench shifts a long pattern through each instruction code and counts how many captured bits come out before `tdi` shows up on `tdo`. A register of the wrong length, or an unlisted code that does not fall back to bypass, fails this count. Access requests are checked on the exact cycle they leave Update-DR. A design with the wrong field slicing would present swapped address or direction bits there, and a design that fires on other instructions would raise the request counter. Back-to-back scans with and without a response expose a block that replays a stale acknowledge instead of WAIT, or that drops the held read data. A reset in the middle of a session shows whether the stored response is cleared.

// File: rtl/jtag_dap_pkg.sv
package jtag_dap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] INS_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] INS_IDCODE = 4'b1110;
  localparam logic [IR_W-1:0] INS_DPACC  = 4'b1010;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_dap_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_e state_q
);

  tap_state_e nxt;

  always_comb begin
    case (state_q)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nxt = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nxt = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      UPD_IR:  nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state_q <= TLR;
    else      state_q <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_dap_pkg::*;
(
  input  logic            tck,
  input  logic            trst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  logic [IR_W-1:0] sr_q;

  always_ff @(posedge tck) begin
    if (trst || state == TLR) begin
      sr_q <= IR_CAPTURE;
      ir_q <= INS_IDCODE;
    end else begin
      case (state)
        CAP_IR:  sr_q <= IR_CAPTURE;
        SH_IR:   sr_q <= {tdi, sr_q[IR_W-1:1]};
        UPD_IR:  ir_q <= sr_q;
        default: ;
      endcase
    end
  end

  assign ir_lsb = sr_q[0];

endmodule

// File: rtl/tap_fixed_regs.sv
module tap_fixed_regs
  import jtag_dap_pkg::*;
#(
  parameter int           ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h3BA00477
) (
  input  logic       tck,
  input  logic       trst,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       byp_lsb,
  output logic       id_lsb
);

  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck) begin
    if (trst) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else begin
      case (state)
        CAP_DR: begin
          byp_q <= 1'b0;
          id_q  <= ID_VALUE;
        end
        SH_DR: begin
          byp_q <= tdi;
          id_q  <= {tdi, id_q[ID_W-1:1]};
        end
        default: ;
      endcase
    end
  end

  assign byp_lsb = byp_q;
  assign id_lsb  = id_q[0];

endmodule

// File: rtl/dp_access_reg.sv
module dp_access_reg
  import jtag_dap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  localparam int ACK_W = ADDR_W + 1,
  localparam int REG_W = DATA_W + ACK_W
) (
  input  logic              tck,
  input  logic              trst,
  input  logic              sel,
  input  tap_state_e        state,
  input  logic              tdi,
  input  logic              rsp_valid,
  input  logic [ACK_W-1:0]  rsp_ack,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              sr_lsb,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_rnw,
  output logic [DATA_W-1:0] req_wdata
);

  localparam logic [ACK_W-1:0] WAIT_CODE = ACK_W'(ACK_WAIT);

  logic [REG_W-1:0]  sr_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ACK_W-1:0]  ack_q;
  logic              have_rsp_q;

  always_ff @(posedge tck) begin
    if (trst) begin
      sr_q       <= '0;
      rdata_q    <= '0;
      ack_q      <= '0;
      have_rsp_q <= 1'b0;
      req_valid  <= 1'b0;
      req_addr   <= '0;
      req_rnw    <= 1'b0;
      req_wdata  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (rsp_valid) begin
        rdata_q    <= rsp_rdata;
        ack_q      <= rsp_ack;
        have_rsp_q <= 1'b1;
      end
      if (sel) begin
        case (state)
          CAP_DR: sr_q <= {rdata_q, have_rsp_q ? ack_q : WAIT_CODE};
          SH_DR:  sr_q <= {tdi, sr_q[REG_W-1:1]};
          UPD_DR: begin
            req_valid  <= 1'b1;
            req_wdata  <= sr_q[REG_W-1:ADDR_W+1];
            req_addr   <= sr_q[ADDR_W:1];
            req_rnw    <= sr_q[0];
            have_rsp_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign sr_lsb = sr_q[0];

endmodule

// File: rtl/jtag_dap_tap.sv
module jtag_dap_tap
  import jtag_dap_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 2,
  parameter logic [31:0]     ID_VALUE = 32'h3BA00477,
  localparam int             ACK_W    = ADDR_W + 1
) (
  input  logic              tck,
  input  logic              trst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_rnw,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [ACK_W-1:0]  rsp_ack,
  input  logic [DATA_W-1:0] rsp_rdata
);

  tap_state_e      tap_state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, byp_lsb, id_lsb, acc_lsb, dr_lsb;
  logic            sel_acc;

  tap_fsm u_fsm (
    .tck(tck), .trst(trst), .tms(tms), .state_q(tap_state)
  );

  tap_ir u_ir (
    .tck(tck), .trst(trst), .state(tap_state), .tdi(tdi),
    .ir_q(ir_q), .ir_lsb(ir_lsb)
  );

  tap_fixed_regs #(.ID_W(32), .ID_VALUE(ID_VALUE)) u_fixed (
    .tck(tck), .trst(trst), .state(tap_state), .tdi(tdi),
    .byp_lsb(byp_lsb), .id_lsb(id_lsb)
  );

  assign sel_acc = (ir_q == INS_DPACC);

  dp_access_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_acc (
    .tck(tck), .trst(trst), .sel(sel_acc), .state(tap_state), .tdi(tdi),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .sr_lsb(acc_lsb), .req_valid(req_valid), .req_addr(req_addr),
    .req_rnw(req_rnw), .req_wdata(req_wdata)
  );

  always_comb begin
    if (ir_q == INS_IDCODE) dr_lsb = id_lsb;
    else if (sel_acc)       dr_lsb = acc_lsb;
    else                    dr_lsb = byp_lsb;
  end

  always_ff @(negedge tck) begin
    if (trst) tdo <= 1'b0;
    else begin
      case (tap_state)
        SH_DR:   tdo <= dr_lsb;
        SH_IR:   tdo <= ir_lsb;
        default: tdo <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/jtag_dap_tap_chk.sv
module jtag_dap_tap_chk
  import jtag_dap_pkg::*;
(
  input logic            tck,
  input logic            trst,
  input logic            tms,
  input logic            tdo,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir,
  input logic            req_valid
);

  assert_trst_idle_R1: assert property (@(posedge tck)
    trst |=> (state == TLR && ir == INS_IDCODE));

  assert_tlr_hold_R2: assert property (@(posedge tck) disable iff (trst)
    (state == TLR && tms) |=> state == TLR);

  assert_ir_stable_R3: assert property (@(posedge tck) disable iff (trst)
    (state != UPD_IR && state != TLR) |=> $stable(ir));

  assert_req_origin_R7: assert property (@(posedge tck) disable iff (trst)
    req_valid |-> $past(state == UPD_DR && ir == INS_DPACC));

  assert_req_pulse_R7: assert property (@(posedge tck) disable iff (trst)
    req_valid |=> !req_valid);

  assert_tdo_idle_R10: assert property (@(posedge tck) disable iff (trst)
    (state != SH_DR && state != SH_IR) |-> !tdo);

endmodule

bind jtag_dap_tap jtag_dap_tap_chk u_chk (
  .tck(tck), .trst(trst), .tms(tms), .tdo(tdo),
  .state(tap_state), .ir(ir_q), .req_valid(req_valid)
);

// File: tb/test_jtag_dap_tap.sv
module test_jtag_dap_tap;

  localparam logic [31:0] ID = 32'h3BA00477;
  localparam logic [63:0] PAT = 64'hA5C3_0F96_1E2D_B487;
  localparam int SCAN_N = 48;

  typedef struct packed {
    logic [3:0] code;
    logic [7:0] len;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'hF, 8'd1}, '{4'hE, 8'd32}, '{4'hA, 8'd35}, '{4'h0, 8'd1},
    '{4'h5, 8'd1}, '{4'hB, 8'd1},  '{4'h7, 8'd1}
  };

  logic        tck = 1'b0;
  logic        trst, tms, tdi, tdo;
  logic        req_valid, req_rnw, rsp_valid;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic [2:0]  rsp_ack;

  int nvec = 0, nfail = 0, req_count = 0;
  bit done = 0;

  always #4 tck = ~tck;

  jtag_dap_tap i_jtag_dap_tap (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata)
  );

  always @(negedge tck) if (!trst && req_valid) req_count++;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    tms = m; tdi = d;
    @(negedge tck); #1; o = tdo;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] capt);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i], o);
      capt[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
    logic o;
    dout = '0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o);
      dout[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  function automatic logic [63:0] capture_of(input logic [3:0] code);
    if (code == 4'hE) return {32'h0, ID};
    if (code == 4'hA) return 64'h1;
    return 64'h0;
  endfunction

  task automatic respond(input logic [31:0] d, input logic [2:0] a);
    logic o;
    rsp_valid = 1; rsp_rdata = d; rsp_ack = a;
    tick(0, 0, o);
    rsp_valid = 0;
  endtask

  initial begin
    logic [63:0] dout, expv;
    logic [3:0]  capt;
    logic        o;
    int          base;
    trst = 1; tms = 1; tdi = 0; rsp_valid = 0; rsp_ack = 0; rsp_rdata = 0;
    repeat (3) @(posedge tck);
    #1; trst = 0;
    tick(0, 0, o);
    check(o == 0, "R10 tdo idle", {63'h0, o}, 64'h0);

    // R1 R5: IDCODE active straight out of reset
    scan_dr(PAT, 32, dout);
    check(dout[31:0] == ID, "R1 R5 reset idcode", dout, {32'h0, ID});
    // R3: capture pattern seen while shifting the instruction
    load_ir(4'hF, capt);
    check(capt == 4'b0001, "R3 ir capture", {60'h0, capt}, 64'h1);

    // Table walk: R4 R5 R6 register selection and lengths
    foreach (VECS[k]) begin
      load_ir(VECS[k].code, capt);
      scan_dr(PAT, SCAN_N, dout);
      expv = '0;
      for (int i = 0; i < SCAN_N; i++)
        expv[i] = (i < int'(VECS[k].len)) ? capture_of(VECS[k].code)[i]
                                          : PAT[i - int'(VECS[k].len)];
      check(dout[SCAN_N-1:0] == expv[SCAN_N-1:0], "R4 R5 R6 table", dout, expv);
    end
    check(req_count == 1, "R7 request only under access code",
          64'(req_count), 64'd1);

    // R1: five TMS-high cycles reach reset and reload IDCODE
    load_ir(4'hF, capt);
    repeat (5) tick(1, 0, o);
    tick(0, 0, o);
    scan_dr(PAT, 32, dout);
    check(dout[31:0] == ID, "R1 tms reset", dout, {32'h0, ID});

    // R6 R7: write request
    load_ir(4'hA, capt);
    base = req_count;
    scan_dr({29'h0, 32'hCAFE1234, 2'b10, 1'b0}, 35, dout);
    check(req_valid && req_wdata == 32'hCAFE1234 && req_addr == 2'b10 && !req_rnw,
          "R6 R7 write request", {29'h0, req_wdata, req_addr, req_rnw, req_valid},
          {29'h0, 32'hCAFE1234, 2'b10, 1'b0, 1'b1});
    tick(0, 0, o);
    check(!req_valid && req_count == base + 1, "R7 single pulse",
          64'(req_count - base), 64'd1);

    // R8: response captured with ack OK
    respond(32'h55AA0FF0, 3'b010);
    scan_dr({29'h0, 32'h0, 2'b01, 1'b1}, 35, dout);
    check(dout[34:0] == {32'h55AA0FF0, 3'b010}, "R8 response capture",
          dout, {29'h0, 32'h55AA0FF0, 3'b010});
    check(req_rnw && req_addr == 2'b01, "R6 read request",
          {61'h0, req_addr, req_rnw}, {61'h0, 2'b01, 1'b1});

    // R9: no response since that request -> WAIT with held data
    scan_dr(64'h0, 35, dout);
    check(dout[34:0] == {32'h55AA0FF0, 3'b001}, "R9 wait code",
          dout, {29'h0, 32'h55AA0FF0, 3'b001});

    // R8: reserved acknowledge passes unchanged
    respond(32'h12345678, 3'b100);
    scan_dr(64'h0, 35, dout);
    check(dout[34:0] == {32'h12345678, 3'b100}, "R8 reserved ack",
          dout, {29'h0, 32'h12345678, 3'b100});

    // R1 R9: trst in the middle clears instruction and stored response
    respond(32'hDEADBEEF, 3'b010);
    trst = 1; tick(0, 0, o); trst = 0;
    tick(0, 0, o);
    scan_dr(PAT, 32, dout);
    check(dout[31:0] == ID, "R1 trst idcode", dout, {32'h0, ID});
    load_ir(4'hA, capt);
    scan_dr(64'h0, 35, dout);
    check(dout[34:0] == 35'h1, "R9 cleared by trst", dout, 64'h1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nvec++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule